// File: doc/BRIEF.md
# Adaptive Loop Time-Constant Supervisor

This block decides how hard a carrier-tracking loop may average. At every baud boundary the loop presents a phase index. The block compares that index with a phase it has remembered. While the two stay close, a stability counter climbs. Once the counter has covered a span proportional to the present time constant, the constant is lengthened by one step. Any signal-quality problem at a boundary drops the constant back to its floor, so the loop can reacquire quickly.

The same boundary also produces the quality verdict. A signal peak that is too small raises an amplitude flag. A poor ratio between signal peak and noise floor raises a modulation flag. The loop frequency estimate is clamped to its capture range, and a flag is raised whenever the clamp acts. An externally detected frame-sync error is folded into the same flag word. When the constant has reached its ceiling and the flag word is clean, a lock-ready output allows the downstream timestamp to be used. Between strobes the block holds all of its state.

Top module: `loop_tc_supervisor`

## Requirements
- R1: During and right after reset the time constant is 2, the flag word is 0, lock_ready is 0 and freq_out is 0; the remembered phase is 0 and the stability counter is 0.
- R2: On a strobe with no flag set, a phase index that differs from the remembered phase by at most 1 (plain difference, no wrap from 79 to 0) increments the stability counter. Any larger difference clears the counter and stores the current index as the remembered phase.
- R3: On a strobe with no flag set, a close phase with the counter already equal to 20 times the time constant advances the time constant by one. It also clears the counter and stores the current index. Growth from value t therefore takes 20·t+1 consecutive close strobes.
- R4: Bit 0 of err_flags is set after a strobe whose sig_max is below 100 (signed compare).
- R5: Bit 2 of err_flags is set after a strobe whose sig_max is 0 or negative, or for which 2·(sig_max − noise_min) < sig_max.
- R6: freq_out takes freq_in clamped to ±2.0 in signed Q8 (±512). Bit 1 of err_flags is set exactly when the clamp changed the value.
- R7: Bit 3 of err_flags copies sync_err at each strobe.
- R8: If any flag bit is set at a strobe, the time constant returns to 2 and the counter clears, and the current index becomes the remembered phase.
- R9: lock_ready is high exactly when the time constant is 10 and err_flags is 0.
- R10: With baud_stb low, tc, err_flags, freq_out and lock_ready do not change, whatever the other inputs do.
- R11: At the ceiling of 10, completing a stability span leaves the time constant at 10 and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_stb | input | 1 | One-cycle baud boundary strobe |
| phase_idx | input | 7 | Envelope crossing phase index, 0 to 79 |
| sig_max | input | 16 | Signed per-baud signal maximum |
| noise_min | input | 16 | Signed per-baud noise minimum |
| freq_in | input | 16 | Signed Q8 loop frequency estimate |
| sync_err | input | 1 | Frame synchronisation error from the decoder |
| tc | output | 4 | Current loop time constant |
| lock_ready | output | 1 | Time constant at ceiling with no error |
| err_flags | output | 4 | {sync, modulation, frequency, amplitude} |
| freq_out | output | 16 | Clamped frequency estimate, signed Q8 |

## Verification
The bench builds the block with its default parameters: floor 2, ceiling 10, a span multiplier of 20, 16-bit amplitudes and a Q8 frequency word. With these values a full climb from floor to ceiling takes 888 clean strobes. That is short enough to drive the constant to its ceiling, run through saturation, and still spend thousands of random strobes on collapses, phase jumps and the exact threshold edges: amplitude 99 and 100, frequency ±512 and ±513, a phase step of 1 against a step of 2, and a non-positive peak.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  // Quality verdict for one baud; amp lands in bit 0 of the packed word.
  typedef struct packed {
    logic sync;
    logic mod;
    logic freq;
    logic amp;
  } tcs_flags_t;
endpackage

// File: rtl/tcs_quality.sv
module tcs_quality
  import tcs_pkg::*;
#(
  parameter int AMP_W        = 16,
  parameter int FREQ_W       = 16,
  parameter int FREQ_FRAC    = 8,
  parameter int FREQ_LIM_INT = 2,
  parameter int DROP_LVL     = 100
) (
  input  logic signed [AMP_W-1:0]  sig_max,
  input  logic signed [AMP_W-1:0]  noise_min,
  input  logic signed [FREQ_W-1:0] freq_in,
  input  logic                     sync_err,
  output tcs_flags_t               flags,
  output logic signed [FREQ_W-1:0] freq_clamped
);
  localparam int EXT_W = AMP_W + 3;
  localparam int LIM   = FREQ_LIM_INT << FREQ_FRAC;
  localparam logic signed [FREQ_W-1:0] LIM_P = FREQ_W'(LIM);
  localparam logic signed [FREQ_W-1:0] LIM_N = FREQ_W'(-LIM);
  localparam logic signed [AMP_W-1:0]  DROP  = AMP_W'(DROP_LVL);

  logic signed [EXT_W-1:0] max_x, nz_x, span2;

  always_comb begin
    max_x = EXT_W'(sig_max);
    nz_x  = EXT_W'(noise_min);
    span2 = (max_x - nz_x) <<< 1;
  end

  always_comb begin
    flags      = '0;
    flags.amp  = (sig_max < DROP);
    flags.mod  = (sig_max <= 0) || (span2 < max_x);
    flags.sync = sync_err;
    if (freq_in > LIM_P) begin
      freq_clamped = LIM_P;
      flags.freq   = 1'b1;
    end else if (freq_in < LIM_N) begin
      freq_clamped = LIM_N;
      flags.freq   = 1'b1;
    end else begin
      freq_clamped = freq_in;
    end
  end
endmodule

// File: rtl/tcs_phase_cmp.sv
module tcs_phase_cmp #(
  parameter int PH_W = 7
) (
  input  logic [PH_W-1:0] cur_ph,
  input  logic [PH_W-1:0] ref_ph,
  output logic            near
);
  logic [PH_W:0] a, b;

  always_comb begin
    a    = {1'b0, cur_ph};
    b    = {1'b0, ref_ph};
    near = (a == b) || (a == b + 1'b1) || (b == a + 1'b1);
  end
endmodule

// File: rtl/tcs_tc_ctrl.sv
module tcs_tc_ctrl #(
  parameter int PH_W      = 7,
  parameter int TC_MIN    = 2,
  parameter int TC_MAX    = 10,
  parameter int STAB_MULT = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stb,
  input  logic                         any_err,
  input  logic [PH_W-1:0]              cur_ph,
  output logic [$clog2(TC_MAX+1)-1:0]  tc,
  output logic [PH_W-1:0]              ref_ph
);
  localparam int TC_W  = $clog2(TC_MAX + 1);
  localparam int CNT_W = $clog2(STAB_MULT * TC_MAX + 1);
  localparam logic [TC_W-1:0] TCMIN_V = TC_W'(TC_MIN);
  localparam logic [TC_W-1:0] TCMAX_V = TC_W'(TC_MAX);

  logic [CNT_W-1:0] cnt, thr;
  logic             near;

  tcs_phase_cmp #(.PH_W(PH_W)) u_cmp (
    .cur_ph (cur_ph),
    .ref_ph (ref_ph),
    .near   (near)
  );

  always_comb thr = CNT_W'(STAB_MULT * int'(tc));

  always_ff @(posedge clk) begin
    if (rst) begin
      tc     <= TCMIN_V;
      cnt    <= '0;
      ref_ph <= '0;
    end else if (stb) begin
      if (any_err) begin
        tc     <= TCMIN_V;
        cnt    <= '0;
        ref_ph <= cur_ph;
      end else if (!near) begin
        cnt    <= '0;
        ref_ph <= cur_ph;
      end else if (cnt >= thr) begin
        tc     <= (tc == TCMAX_V) ? TCMAX_V : tc + 1'b1;
        cnt    <= '0;
        ref_ph <= cur_ph;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end

  AST_TC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tc >= TCMIN_V) && (tc <= TCMAX_V)); // R1
  AST_CNT_SPAN: assert property (@(posedge clk) disable iff (rst)
    cnt <= thr); // R3
  AST_TC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tc == $past(tc)) || (tc == $past(tc) + 1'b1) || (tc == TCMIN_V)); // R3
  AST_ERR_DROP: assert property (@(posedge clk) disable iff (rst)
    (stb && any_err) |=> (tc == TCMIN_V)); // R8
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(tc)); // R10
endmodule

// File: rtl/loop_tc_supervisor.sv
module loop_tc_supervisor
  import tcs_pkg::*;
#(
  parameter int PH_W         = 7,
  parameter int AMP_W        = 16,
  parameter int FREQ_W       = 16,
  parameter int FREQ_FRAC    = 8,
  parameter int FREQ_LIM_INT = 2,
  parameter int DROP_LVL     = 100,
  parameter int TC_MIN       = 2,
  parameter int TC_MAX       = 10,
  parameter int STAB_MULT    = 20,
  localparam int TC_W        = $clog2(TC_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     baud_stb,
  input  logic [PH_W-1:0]          phase_idx,
  input  logic signed [AMP_W-1:0]  sig_max,
  input  logic signed [AMP_W-1:0]  noise_min,
  input  logic signed [FREQ_W-1:0] freq_in,
  input  logic                     sync_err,
  output logic [TC_W-1:0]          tc,
  output logic                     lock_ready,
  output logic [3:0]               err_flags,
  output logic signed [FREQ_W-1:0] freq_out
);
  localparam int LIM = FREQ_LIM_INT << FREQ_FRAC;

  tcs_flags_t              flg_now, flg_q;
  logic signed [FREQ_W-1:0] f_clamp;
  logic [PH_W-1:0]          ref_ph;

  tcs_quality #(
    .AMP_W(AMP_W), .FREQ_W(FREQ_W), .FREQ_FRAC(FREQ_FRAC),
    .FREQ_LIM_INT(FREQ_LIM_INT), .DROP_LVL(DROP_LVL)
  ) u_qual (
    .sig_max      (sig_max),
    .noise_min    (noise_min),
    .freq_in      (freq_in),
    .sync_err     (sync_err),
    .flags        (flg_now),
    .freq_clamped (f_clamp)
  );

  tcs_tc_ctrl #(
    .PH_W(PH_W), .TC_MIN(TC_MIN), .TC_MAX(TC_MAX), .STAB_MULT(STAB_MULT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stb     (baud_stb),
    .any_err (|flg_now),
    .cur_ph  (phase_idx),
    .tc      (tc),
    .ref_ph  (ref_ph)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q    <= '0;
      freq_out <= '0;
    end else if (baud_stb) begin
      flg_q    <= flg_now;
      freq_out <= f_clamp;
    end
  end

  assign err_flags  = flg_q;
  assign lock_ready = (tc == TC_W'(TC_MAX)) && (flg_q == '0);

  AST_FREQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    (freq_out <= FREQ_W'(LIM)) && (freq_out >= FREQ_W'(-LIM))); // R6
  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (rst)
    (baud_stb && sync_err) |=> err_flags[3] && (tc == TC_W'(TC_MIN))); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !baud_stb |=> $stable(err_flags) && $stable(freq_out)); // R10
  AST_LOW_AMP: assert property (@(posedge clk) disable iff (rst)
    (baud_stb && (sig_max < 0)) |=> err_flags[0] && err_flags[2]); // R4
endmodule

// File: tb/loop_tc_supervisor_tb.sv
module loop_tc_supervisor_tb;
  logic clk = 0;
  logic rst;
  logic baud_stb;
  logic [6:0] phase_idx;
  logic signed [15:0] sig_max, noise_min, freq_in;
  logic sync_err;
  logic [3:0] tc;
  logic lock_ready;
  logic [3:0] err_flags;
  logic signed [15:0] freq_out;

  int n_chk = 0, n_fail = 0;
  int m_tc, m_cnt, m_ref;
  logic [3:0] m_flags;
  int m_freq;

  always #10 clk = ~clk;

  loop_tc_supervisor u_dut (
    .clk(clk), .rst(rst), .baud_stb(baud_stb), .phase_idx(phase_idx),
    .sig_max(sig_max), .noise_min(noise_min), .freq_in(freq_in),
    .sync_err(sync_err), .tc(tc), .lock_ready(lock_ready),
    .err_flags(err_flags), .freq_out(freq_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(int mx, int nz, int fr, bit sy);
    logic [3:0] f;
    f[0] = (mx < 100);
    f[2] = (mx <= 0) || (2 * (mx - nz) < mx);
    f[1] = (fr > 512) || (fr < -512);
    f[3] = sy;
    return f;
  endfunction

  function automatic int clampf(int fr);
    if (fr > 512) return 512;
    if (fr < -512) return -512;
    return fr;
  endfunction

  task automatic check_all(input string tg);
    chk(tc == 4'(m_tc), {tg, " R3 tc"}, tc, m_tc);
    chk(err_flags == m_flags, {tg, " R4 R5 R7 flags"}, err_flags, m_flags);
    chk(int'(freq_out) == m_freq, {tg, " R6 freq"}, freq_out, m_freq);
    chk(lock_ready == (m_tc == 10 && m_flags == 0), {tg, " R9 lock"},
        lock_ready, (m_tc == 10 && m_flags == 0));
  endtask

  task automatic baud(input int ph, input int mx, input int nz, input int fr,
                      input bit sy, input string tg);
    int d;
    phase_idx = 7'(ph); sig_max = 16'(mx); noise_min = 16'(nz);
    freq_in = 16'(fr); sync_err = sy; baud_stb = 1;
    @(negedge clk);
    baud_stb = 0;
    m_flags = exp_flags(mx, nz, fr, sy);
    m_freq  = clampf(fr);
    d = ph - m_ref;
    if (m_flags != 0) begin            // R8
      m_tc = 2; m_cnt = 0; m_ref = ph;
    end else if (d > 1 || d < -1) begin // R2
      m_cnt = 0; m_ref = ph;
    end else if (m_cnt == 20 * m_tc) begin // R3 R11
      if (m_tc < 10) m_tc++;
      m_cnt = 0; m_ref = ph;
    end else m_cnt++;
    check_all(tg);
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst = 1; baud_stb = 0; phase_idx = 0; sig_max = 0; noise_min = 0;
    freq_in = 0; sync_err = 0;
    m_tc = 2; m_cnt = 0; m_ref = 0; m_flags = 0; m_freq = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 0;
    @(negedge clk);
    check_all("R1 after");

    // Directed edges of the quality tests
    baud(0, 99, 0, 0, 0, "R4 amp99");
    baud(0, 100, 0, 0, 0, "R4 amp100");
    baud(0, 0, -5, 0, 0, "R5 max0");
    baud(0, 1000, 600, 0, 0, "R5 poorratio");
    baud(0, 1000, 500, 0, 0, "R5 ratio_edge");
    baud(0, 1000, 0, 512, 0, "R6 pos512");
    baud(0, 1000, 0, 513, 0, "R6 pos513");
    baud(0, 1000, 0, -513, 0, "R6 neg513");
    baud(0, 1000, 0, -512, 0, "R6 neg512");
    baud(0, 1000, 0, 0, 1, "R7 sync");
    // Phase step of 2 restarts the span, step of 1 keeps it
    baud(40, 1000, 0, 0, 0, "R2 jump");
    baud(41, 1000, 0, 0, 0, "R2 step1");
    baud(43, 1000, 0, 0, 0, "R2 step2");

    // Clean climb to the ceiling and through saturation
    for (int i = 0; i < 1100; i++)
      baud(43 + ((i % 3) == 0 ? 1 : 0), 2000, 100, 10, 0, "R11 climb");
    chk(tc == 4'd10, "R11 at_ceiling", tc, 10);
    chk(lock_ready == 1'b1, "R9 lock_high", lock_ready, 1);

    // No strobe: outputs hold
    for (int i = 0; i < 5; i++) begin
      phase_idx = 7'($urandom_range(79)); sig_max = -16'sd5; sync_err = 1;
      freq_in = 16'sd3000;
      @(negedge clk);
      check_all("R10 hold");
    end
    baud(43, 1000, 0, 0, 1, "R8 collapse");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int c, ph, mx, nz, fr;
      bit sy;
      c  = int'($urandom_range(99));
      ph = m_ref + int'($urandom_range(2)) - 1;
      if (c < 3 || ph < 0 || ph > 79) ph = int'($urandom_range(79));
      mx = 500 + int'($urandom_range(2000));
      nz = int'($urandom_range(200));
      fr = int'($urandom_range(800)) - 400;
      sy = 0;
      if (c == 3) mx = int'($urandom_range(120)) - 20;
      if (c == 4) nz = mx - int'($urandom_range(mx / 2 + 2));
      if (c == 5) fr = int'($urandom_range(2000)) - 1000;
      if (c == 6) sy = 1;
      if ((c % 7) == 0 && !baud_stb) @(negedge clk);
      baud(ph, mx, nz, fr, sy, "R2 R3 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule